// File: doc/BRIEF.md
# Hexagonal Grid Cut-Size Evaluator

This block scores one spin configuration on a rectangular array of cells wired as a hexagonal lattice (default 28 columns by 20 rows, 560 spins). Every cell owns three of its six links, so each link of the lattice has exactly one enable bit. Given a full spin vector and the full link-enable map, the block reports three figures: how many enabled links lie inside the array, how many of those join cells of opposite spin (the cut size), and the Ising energy of the configuration with every enabled link carrying an antiferromagnetic coupling of unit strength.

The evaluation is row-serial. A start pulse launches a scan that visits one row per clock and adds that row's owned links into two running sums. A one-cycle done strobe marks the moment all three results are valid. The results then stay put until the next scan completes. The spin and enable inputs must be held steady from the start pulse until done. The array width and height are parameters.

Top module: `hexcut_eval`

## Requirements
- R1: While reset is asserted and after its release, before any scan, done is low and edge_count, cut_count and energy are all zero.
- R2: Spin of the cell at row r, column c is spin_vec bit r*COLS+c, and its three owned links use link_en bits 3*(r*COLS+c)+0 (east, to (r,c+1)), +1 (south-east) and +2 (south-west). Odd rows sit half a cell to the right: from an even row, south-east is (r+1,c) and south-west is (r+1,c-1); from an odd row, south-east is (r+1,c+1) and south-west is (r+1,c).
- R3: edge_count equals the number of set link_en bits whose link ends on a cell inside the array.
- R4: A link_en bit whose link would leave the array (east from the last column, any downward link from the last row, south-east from the last column of an odd row, south-west from column 0 of an even row) has no effect on any output.
- R5: cut_count equals the number of counted links whose two end cells hold different spin bits.
- R6: With spin bit 0 meaning -1 and 1 meaning +1, energy is the sum over counted links of the product of the two spin values, a two's-complement number equal to edge_count minus twice cut_count.
- R7: When start is sampled high while idle, done is high for exactly one cycle, ROWS+1 clock edges after that sampling edge (the sampling edge counting as the first).
- R8: edge_count, cut_count and energy change only on the edge that raises done, and hold their values otherwise, including while inputs change between scans.
- R9: A start pulse received while a scan is in progress is ignored: the running scan finishes at its original time and no further done follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a scan when sampled high while idle |
| spin_vec | input | ROWS*COLS | One spin bit per cell, row-major |
| link_en | input | 3*ROWS*COLS | Three owned-link enable bits per cell |
| done | output | 1 | One-cycle strobe, results valid |
| edge_count | output | EW | Number of enabled in-array links |
| cut_count | output | EW | Number of enabled links joining opposite spins |
| energy | output | EW+1 | Signed Ising energy, edge_count minus twice cut_count |

## Verification
The hardest situations to reach are those at the array edges in odd rows, where the south-east link of the last column and the south-west link of column 0 swap validity compared with even rows; a random fill rarely isolates them. The stimulus builds maps with a single enable bit placed on each such corner, plus a map containing only links that point off the array, so that one wrong neighbour rule shows up as a count of one instead of zero. Hand-derived totals for uniform, column-alternating and row-alternating spins pin the lattice orientation, and a second start pulse injected mid-scan checks that the strobe timing is not disturbed.

// File: rtl/hexcut_pkg.sv
package hexcut_pkg;

  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;

  // Position of each owned link inside a cell's three enable bits
  localparam int unsigned SLOT_EAST = 0;
  localparam int unsigned SLOT_SE   = 1;
  localparam int unsigned SLOT_SW   = 2;
  localparam int unsigned SLOTS     = 3;

endpackage

// File: rtl/hexcut_row_eval.sv
module hexcut_row_eval #(
  parameter int COLS = 28,
  parameter int RW   = 7
) (
  input  logic [COLS-1:0]   cur_spin,
  input  logic [COLS-1:0]   nxt_spin,
  input  logic [3*COLS-1:0] cur_en,
  input  logic              odd_row,
  input  logic              last_row,
  output logic [RW-1:0]     row_edges,
  output logic [RW-1:0]     row_cut
);
  import hexcut_pkg::*;

  localparam int LINKS = SLOTS * COLS;

  logic [LINKS-1:0] link_ok;
  logic [LINKS-1:0] link_cut;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic se_peer, sw_peer;
    logic se_valid, sw_valid;

    // east link stays within the same row
    if (c < COLS - 1) begin : g_east
      assign link_ok[SLOTS*c+SLOT_EAST]  = cur_en[SLOTS*c+SLOT_EAST];
      assign link_cut[SLOTS*c+SLOT_EAST] = cur_en[SLOTS*c+SLOT_EAST] &
                                           (cur_spin[c] ^ cur_spin[c+1]);
    end else begin : g_east_edge
      assign link_ok[SLOTS*c+SLOT_EAST]  = 1'b0;
      assign link_cut[SLOTS*c+SLOT_EAST] = 1'b0;
    end

    // south-east: straight below for even rows, one to the right for odd rows
    if (c < COLS - 1) begin : g_se
      assign se_peer  = odd_row ? nxt_spin[c+1] : nxt_spin[c];
      assign se_valid = !last_row;
    end else begin : g_se_edge
      assign se_peer  = nxt_spin[c];
      assign se_valid = !last_row && !odd_row;
    end

    // south-west: one to the left for even rows, straight below for odd rows
    if (c > 0) begin : g_sw
      assign sw_peer  = odd_row ? nxt_spin[c] : nxt_spin[c-1];
      assign sw_valid = !last_row;
    end else begin : g_sw_edge
      assign sw_peer  = nxt_spin[c];
      assign sw_valid = !last_row && odd_row;
    end

    assign link_ok[SLOTS*c+SLOT_SE]  = cur_en[SLOTS*c+SLOT_SE] & se_valid;
    assign link_ok[SLOTS*c+SLOT_SW]  = cur_en[SLOTS*c+SLOT_SW] & sw_valid;
    assign link_cut[SLOTS*c+SLOT_SE] = link_ok[SLOTS*c+SLOT_SE] & (cur_spin[c] ^ se_peer);
    assign link_cut[SLOTS*c+SLOT_SW] = link_ok[SLOTS*c+SLOT_SW] & (cur_spin[c] ^ sw_peer);
  end

  always_comb begin
    row_edges = '0;
    row_cut   = '0;
    for (int i = 0; i < LINKS; i++) begin
      row_edges = row_edges + RW'(link_ok[i]);
      row_cut   = row_cut + RW'(link_cut[i]);
    end
  end

endmodule

// File: rtl/hexcut_scan_ctrl.sv
module hexcut_scan_ctrl #(
  parameter int ROWS = 20,
  parameter int AW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] row_idx,
  output logic          scan_busy,
  output logic          launch,
  output logic          last_step,
  output logic          done_pulse
);
  import hexcut_pkg::*;

  scan_state_e state_q;

  assign scan_busy = (state_q == SCAN_RUN);
  assign launch    = start && !scan_busy;
  assign last_step = scan_busy && (row_idx == AW'(ROWS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SCAN_IDLE;
      row_idx    <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (launch) begin
        state_q <= SCAN_RUN;
        row_idx <= '0;
      end else if (last_step) begin
        state_q    <= SCAN_IDLE;
        row_idx    <= '0;
        done_pulse <= 1'b1;
      end else if (scan_busy) begin
        row_idx <= row_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/hexcut_eval.sv
module hexcut_eval #(
  parameter int COLS = 28,
  parameter int ROWS = 20,
  localparam int N   = COLS * ROWS,
  localparam int NE  = 3 * N,
  localparam int EW  = $clog2(NE + 1),
  localparam int EGW = EW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [N-1:0]          spin_vec,
  input  logic [NE-1:0]         link_en,
  output logic                  done,
  output logic [EW-1:0]         edge_count,
  output logic [EW-1:0]         cut_count,
  output logic signed [EGW-1:0] energy
);

  localparam int RW = $clog2(3 * COLS + 1);
  localparam int AW = (ROWS > 1) ? $clog2(ROWS) : 1;

  // energy with each link coupling antiferromagnetically: edges - 2*cut
  function automatic logic signed [EGW-1:0] ising_of(input logic [EW-1:0] e,
                                                     input logic [EW-1:0] k);
    return $signed({1'b0, e}) - $signed({k, 1'b0});
  endfunction

  logic [AW-1:0]     row_idx;
  logic [AW-1:0]     nxt_idx;
  logic              scan_busy;
  logic              launch;
  logic              last_step;
  logic              done_pulse;
  logic              last_row;
  logic [COLS-1:0]   cur_spin;
  logic [COLS-1:0]   nxt_spin;
  logic [3*COLS-1:0] cur_en;
  logic [RW-1:0]     row_edges;
  logic [RW-1:0]     row_cut;
  logic [EW-1:0]     acc_edges;
  logic [EW-1:0]     acc_cut;
  logic [EW-1:0]     sum_edges;
  logic [EW-1:0]     sum_cut;

  hexcut_scan_ctrl #(
    .ROWS (ROWS),
    .AW   (AW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .row_idx    (row_idx),
    .scan_busy  (scan_busy),
    .launch     (launch),
    .last_step  (last_step),
    .done_pulse (done_pulse)
  );

  assign last_row = (row_idx == AW'(ROWS - 1));
  assign nxt_idx  = last_row ? row_idx : row_idx + 1'b1;
  assign cur_spin = spin_vec[int'(row_idx) * COLS +: COLS];
  assign nxt_spin = spin_vec[int'(nxt_idx) * COLS +: COLS];
  assign cur_en   = link_en[int'(row_idx) * 3 * COLS +: 3 * COLS];

  hexcut_row_eval #(
    .COLS (COLS),
    .RW   (RW)
  ) u_row (
    .cur_spin  (cur_spin),
    .nxt_spin  (nxt_spin),
    .cur_en    (cur_en),
    .odd_row   (row_idx[0]),
    .last_row  (last_row),
    .row_edges (row_edges),
    .row_cut   (row_cut)
  );

  assign sum_edges = acc_edges + EW'(row_edges);
  assign sum_cut   = acc_cut + EW'(row_cut);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_edges <= '0;
      acc_cut   <= '0;
    end else if (launch) begin
      acc_edges <= '0;
      acc_cut   <= '0;
    end else if (scan_busy) begin
      acc_edges <= sum_edges;
      acc_cut   <= sum_cut;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_count <= '0;
      cut_count  <= '0;
      energy     <= '0;
    end else if (last_step) begin
      edge_count <= sum_edges;
      cut_count  <= sum_cut;
      energy     <= ising_of(sum_edges, sum_cut);
    end
  end

  assign done = done_pulse;

endmodule

// File: rtl/hexcut_eval_chk.sv
module hexcut_eval_chk #(
  parameter int COLS = 28,
  parameter int ROWS = 20,
  parameter int EW   = 11,
  parameter int EGW  = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  done,
  input logic                  scan_busy,
  input logic                  launch,
  input logic [EW-1:0]         edge_count,
  input logic [EW-1:0]         cut_count,
  input logic signed [EGW-1:0] energy
);

  localparam int MAX_LINKS = (COLS - 1) * ROWS + (ROWS - 1) * (2 * COLS - 1);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !scan_busy);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(edge_count) && $stable(cut_count) && $stable(energy)));

  p_edge_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(edge_count) <= MAX_LINKS);

  p_cut_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cut_count <= edge_count);

  p_energy_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (energy <= $signed({1'b0, edge_count})) && (energy >= -$signed({1'b0, edge_count})));

  p_scan_from_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_busy) |-> $past(launch));

endmodule

bind hexcut_eval hexcut_eval_chk #(
  .COLS (COLS),
  .ROWS (ROWS),
  .EW   (EW),
  .EGW  (EGW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done       (done),
  .scan_busy  (scan_busy),
  .launch     (launch),
  .edge_count (edge_count),
  .cut_count  (cut_count),
  .energy     (energy)
);

// File: tb/hexcut_eval_tb.sv
module hexcut_eval_tb;

  localparam int COLS = 28;
  localparam int ROWS = 20;
  localparam int N    = COLS * ROWS;
  localparam int NE   = 3 * N;
  localparam int EW   = $clog2(NE + 1);
  localparam int EGW  = EW + 1;

  // stimulus table: {spin pattern, link pattern}
  // spin: 0 all low, 1 all high, 2 column parity, 3 row parity, 4 random
  // link: 0 none, 1 all, 2 east only, 3 random, 4 off-array only
  localparam int NV = 9;
  localparam logic [7:0] VEC [NV] = '{
    8'h01, 8'h11, 8'h21, 8'h31, 8'h41, 8'h43, 8'h23, 8'h42, 8'h40
  };

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  start = 1'b0;
  logic [N-1:0]          spin_vec = '0;
  logic [NE-1:0]         link_en = '0;
  logic                  done;
  logic [EW-1:0]         edge_count;
  logic [EW-1:0]         cut_count;
  logic signed [EGW-1:0] energy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hexcut_eval #(.COLS(COLS), .ROWS(ROWS)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .spin_vec   (spin_vec),
    .link_en    (link_en),
    .done       (done),
    .edge_count (edge_count),
    .cut_count  (cut_count),
    .energy     (energy)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] gen_spin(input int pat, input int seed);
    logic [N-1:0] v;
    logic [31:0] x;
    x = 32'h9E37_79B9 ^ 32'(seed);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        case (pat)
          0: v[r*COLS+c] = 1'b0;
          1: v[r*COLS+c] = 1'b1;
          2: v[r*COLS+c] = c[0];
          3: v[r*COLS+c] = r[0];
          default: v[r*COLS+c] = x[7];
        endcase
      end
    end
    return v;
  endfunction

  function automatic logic [NE-1:0] gen_links(input int pat, input int seed);
    logic [NE-1:0] v;
    logic [31:0] x;
    x = 32'h1234_5678 + 32'(seed);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        for (int s = 0; s < 3; s++) begin
          x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
          case (pat)
            0: v[3*(r*COLS+c)+s] = 1'b0;
            1: v[3*(r*COLS+c)+s] = 1'b1;
            2: v[3*(r*COLS+c)+s] = (s == 0);
            3: v[3*(r*COLS+c)+s] = x[11];
            default: v[3*(r*COLS+c)+s] =
              (s == 0 && c == COLS-1) || (s != 0 && r == ROWS-1) ||
              (s == 1 && r[0] && c == COLS-1) || (s == 2 && !r[0] && c == 0);
          endcase
        end
      end
    end
    return v;
  endfunction

  // reference: doubled-width coordinates, x = 2c + (r odd); lower neighbours at x+-1
  task automatic model(input logic [N-1:0] sp, input logic [NE-1:0] le,
                       output int e, output int k);
    e = 0; k = 0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int x;
        int a;
        x = 2 * c + (r % 2);
        a = r * COLS + c;
        if (c + 1 < COLS && le[3*a]) begin
          e++; if (sp[a] != sp[a+1]) k++;
        end
        if (r + 1 < ROWS) begin
          for (int d = 0; d < 2; d++) begin
            int tx;
            int tc;
            int b;
            tx = (d == 0) ? x + 1 : x - 1;
            tc = (tx - ((r + 1) % 2)) / 2;
            if (tx >= 0 && tc >= 0 && tc < COLS && le[3*a + 1 + d]) begin
              b = (r + 1) * COLS + tc;
              e++; if (sp[a] != sp[b]) k++;
            end
          end
        end
      end
    end
  endtask

  // launches a scan and checks strobe timing; results sampled when done shows
  task automatic run_scan(input string tag, output int e, output int k, output int g);
    bit early;
    early = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 1; i <= ROWS; i++) begin
      @(negedge clk);
      if (i < ROWS && done) early = 1'b1;
    end
    check({"R7 no early done ", tag}, int'(early), 0);
    check({"R7 done at latency ", tag}, int'(done), 1);
    e = int'(edge_count);
    k = int'(cut_count);
    g = int'(energy);
    @(negedge clk);
    check({"R7 done one cycle ", tag}, int'(done), 0);
  endtask

  task automatic score(input string tag, input int exp_e, input int exp_k);
    int e, k, g;
    run_scan(tag, e, k, g);
    check({"R3 edges ", tag}, e, exp_e);
    check({"R5 cut ", tag}, k, exp_k);
    check({"R6 energy ", tag}, g, exp_e - 2 * exp_k);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic single_link(input string tag, input int r, input int c, input int s,
                             input int exp_e);
    spin_vec = '0;
    spin_vec[r*COLS+c] = 1'b1;
    link_en = '0;
    link_en[3*(r*COLS+c)+s] = 1'b1;
    score(tag, exp_e, exp_e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    int e, k, g;
    int e0, k0, g0;
    bit extra;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 done in reset", int'(done), 0);
    check("R1 edges in reset", int'(edge_count), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 done after reset", int'(done), 0);
    check("R1 cut after reset", int'(cut_count), 0);
    check("R1 energy after reset", int'(energy), 0);

    // table walk against the reference model (R3 R4 R5 R6)
    for (int v = 0; v < NV; v++) begin
      spin_vec = gen_spin(int'(VEC[v][7:4]), v + 1);
      link_en  = gen_links(int'(VEC[v][3:0]), 7 * v + 3);
      model(spin_vec, link_en, e, k);
      score($sformatf("vec%0d", v), e, k);
    end

    // hand-derived totals that fix the lattice orientation (R2)
    spin_vec = gen_spin(1, 0); link_en = gen_links(1, 0);
    score("R2 uniform spins", 1585, 0);
    spin_vec = gen_spin(2, 0);
    score("R2 column parity", 1585, 1053);
    spin_vec = gen_spin(3, 0);
    score("R2 row parity", 1585, 1045);

    // off-array links alone (R4)
    spin_vec = gen_spin(4, 99); link_en = gen_links(4, 0);
    score("R4 off-array only", 0, 0);

    // single-link corner cases (R2 R4)
    single_link("R2 even last col SE", 0, COLS-1, 1, 1);
    single_link("R4 odd last col SE", 1, COLS-1, 1, 0);
    single_link("R4 even col0 SW", 0, 0, 2, 0);
    single_link("R2 odd col0 SW", 1, 0, 2, 1);
    single_link("R2 odd mid SE", 3, 5, 1, 1);
    single_link("R4 last row SW", ROWS-1, 4, 2, 0);

    // R8 outputs hold while inputs change between scans
    spin_vec = gen_spin(4, 5); link_en = gen_links(3, 5);
    model(spin_vec, link_en, e, k);
    run_scan("R8 setup", e0, k0, g0);
    spin_vec = gen_spin(2, 0); link_en = gen_links(1, 0);
    repeat (10) @(negedge clk);
    check("R8 edges held", int'(edge_count), e0);
    check("R8 cut held", int'(cut_count), k0);
    check("R8 energy held", int'(energy), g0);

    // R9 second start mid-scan is ignored
    spin_vec = gen_spin(3, 0); link_en = gen_links(1, 0);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 1; i <= ROWS; i++) begin
      @(negedge clk);
      if (i == 5) start = 1'b1;
      if (i == 6) start = 1'b0;
    end
    check("R9 done on schedule", int'(done), 1);
    check("R9 cut of running scan", int'(cut_count), 1045);
    extra = 1'b0;
    for (int i = 0; i < ROWS + 4; i++) begin
      @(negedge clk);
      if (done) extra = 1'b1;
    end
    check("R9 no second done", int'(extra), 0);

    summary();
  end

endmodule